// File: doc/BRIEF.md
# Tuner configuration I2C slave

This block is the control-port slave of a tuner. It watches the two-wire bus with a fast system clock, through synchronizers on both lines. It recognises START, repeated START and STOP, and it answers on one 7-bit address. The lowest bit of that address comes from a strap pin, so two tuners can share one bus. It holds twelve writable configuration bytes, which come out of reset at their working defaults. It also presents two read-only status bytes, built from a power-on flag and from status inputs.

A host writes by sending the address, a register pointer and then any number of data bytes. The pointer advances after every byte and wraps around the fourteen-entry map. To read, the host sets the pointer with a write and then sends a repeated START with the read address. The block returns successive bytes MSB first until the host answers with NACK. Every configuration byte is also driven out in parallel on a flat bus. A write to one chosen register produces a single-cycle start pulse for the VCO selection engine.

Top module: `tuner_cfg_slave`

## Requirements
- R1: The slave answers address 110000s, where s is `addr_strap`. This gives write/read bytes 0xC0/0xC1 with the strap low and 0xC2/0xC3 with it high. It acknowledges by pulling SDA low through the ninth SCL pulse of the address byte.
- R2: On an address that does not match, the slave does not acknowledge and does not drive SDA. It also ignores every later byte until the next START, so no register changes.
- R3: A write transaction is address (R/W=0), then a pointer byte, then data bytes. Every byte is acknowledged, and each data byte goes to the pointer, which then advances by one.
- R4: After a repeated START with R/W=1, the slave returns the byte at the pointer and each following byte, MSB first. The pointer advances per byte. A NACK from the host ends the read, and SDA is released.
- R5: Reset values are as follows. Byte 0 is 0x80, byte 1 is 0x23, byte 2 is 0x02, byte 3 is 0xF6, byte 4 is 0x84 and byte 5 is 0x01. Byte 6 is 0xC0, byte 7 is 0xCC and byte 8 is 0x4B. Bytes 9 to 11 are 0x00, `sda_oe` is 0 and `vas_start` is 0.
- R6: Writes to the status addresses 0x0C and 0x0D are acknowledged but change nothing. When the pointer advances past 0x0D, it wraps to 0x00.
- R7: Status byte 0x0C holds the power-on flag in bit 7 and `stat_flags_in[2:0]` in bits 6..4, with bits 3..0 at zero. Status byte 0x0D equals `stat_rb_in`.
- R8: The power-on flag is 1 after reset. It clears only after a transaction that read byte 0x0C has ended with STOP. A repeated START does not clear it.
- R9: A completed data-byte write to register 0x05 gives exactly one single-cycle `vas_start` pulse. Writes to other registers give none.
- R10: `cfg_flat[8k+7:8k]` always equals configuration byte k.
- R11: SDA is released (`sda_oe`=0) in the cycle after a STOP is seen, and it stays released while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_strap | input | 1 | Lowest slave-address bit |
| stat_flags_in | input | 3 | Flags shown in bits 6..4 of status byte 0x0C |
| stat_rb_in | input | 8 | Readback byte shown at 0x0D |
| cfg_flat | output | 96 | All twelve configuration bytes, byte k at bits 8k+7:8k |
| vas_start | output | 1 | One-cycle pulse after a write to register 0x05 |

## Verification
The bound checker watches four things on every cycle. It checks that the start pulse lasts one cycle and always follows a write to register 0x05. It checks that a write aimed at a status address leaves the parallel outputs unchanged. It also checks that the power-on flag never sets again once cleared and falls only two cycles after a STOP, and that SDA is released after every STOP. Only the bench scenarios can show the byte-level protocol. That covers address matching with both strap values, silence on a foreign address, and pointer increment and wrap. It also covers read data order, status content, and the rule that a repeated START keeps the power-on flag.

// File: rtl/tuner_cfg_pkg.sv
// Package: shared types and reset values for the tuner configuration slave.
// Assumes byte-wide registers; the default table is indexed by register number.
package tuner_cfg_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RX,
        ENG_ACK,
        ENG_TX,
        ENG_TXACK
    } eng_state_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_t;

    // Working reset value of configuration byte idx.
    function automatic logic [7:0] cfg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h23;
            2:       return 8'h02;
            3:       return 8'hF6;
            4:       return 8'h84;
            5:       return 8'h01;
            6:       return 8'hC0;
            7:       return 8'hCC;
            8:       return 8'h4B;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
// Module: synchronizes SCL/SDA into the system clock domain and flags
// SCL edges plus START and STOP conditions.
// Assumes clk runs at least 10x the SCL rate; idle bus level is high.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_now;

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_lvl = sda_sync[SYNC_STAGES-1];

    // Synchronizer chains and one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_now;
            sda_q    <= sda_lvl;
        end
    end

    // Edge and bus-condition decode; SDA moves with SCL high are conditions only.
    always_comb begin
        scl_rise  = scl_now & ~scl_q;
        scl_fall  = ~scl_now & scl_q;
        bus_start = scl_now & scl_q & sda_q & ~sda_lvl;
        bus_stop  = scl_now & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/i2c_slave_engine.sv
// Module: byte-level slave protocol: address match, pointer load,
// write strobes with pointer auto-increment, read shifting and ACK handling.
// Assumes one-cycle pulses for SCL edges and bus conditions from the sampler.
module i2c_slave_engine
    import tuner_cfg_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         PTR_W    = 8,
    parameter int         NUM_ADDR = 14,
    parameter int         STAT_IDX = 12,
    parameter logic [5:0] ADDR_HI  = 6'b110000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             addr_strap,
    input  logic [DW-1:0]    rd_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             sda_oe,
    output logic             por_clr
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DW);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DW - 1);

    eng_state_t       state;
    byte_kind_t       kind;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]    shreg;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] next_ptr;
    logic             rw_bit;
    logic             host_ack;
    logic             stat_read;

    assign rd_addr = ptr;

    // Pointer advance with wrap at the top of the map.
    always_comb begin
        if (ptr >= PTR_W'(NUM_ADDR - 1)) next_ptr = '0;
        else                             next_ptr = ptr + 1'b1;
    end

    // Protocol state machine; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            kind      <= BK_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rw_bit    <= 1'b0;
            host_ack  <= 1'b0;
            stat_read <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            por_clr   <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            por_clr <= 1'b0;
            if (bus_start) begin
                state  <= ENG_RX;
                kind   <= BK_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                state     <= ENG_IDLE;
                sda_oe    <= 1'b0;
                por_clr   <= stat_read;
                stat_read <= 1'b0;
            end else begin
                case (state)
                    ENG_RX: begin
                        if (scl_rise && bitcnt != BYTE_DONE) begin
                            shreg  <= {shreg[DW-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BYTE_DONE) begin
                            bitcnt <= '0;
                            case (kind)
                                BK_ADDR: begin
                                    if (shreg[DW-1:1] == {ADDR_HI, addr_strap}) begin
                                        rw_bit <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ENG_ACK;
                                    end else begin
                                        state <= ENG_IDLE;
                                    end
                                end
                                BK_PTR: begin
                                    ptr    <= PTR_W'(shreg);
                                    sda_oe <= 1'b1;
                                    state  <= ENG_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= next_ptr;
                                    sda_oe  <= 1'b1;
                                    state   <= ENG_ACK;
                                end
                            endcase
                        end
                    end
                    ENG_ACK: begin
                        if (scl_fall) begin
                            if (kind == BK_ADDR && rw_bit) begin
                                shreg    <= rd_data;
                                sda_oe   <= ~rd_data[DW-1];
                                ptr      <= next_ptr;
                                bitcnt   <= '0;
                                host_ack <= 1'b0;
                                state    <= ENG_TX;
                                if (ptr == PTR_W'(STAT_IDX)) stat_read <= 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ENG_RX;
                                kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                            end
                        end
                    end
                    ENG_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ENG_TXACK;
                            end else begin
                                shreg  <= {shreg[DW-2:0], 1'b0};
                                sda_oe <= ~shreg[DW-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ENG_TXACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg    <= rd_data;
                                sda_oe   <= ~rd_data[DW-1];
                                ptr      <= next_ptr;
                                bitcnt   <= '0;
                                host_ack <= 1'b0;
                                state    <= ENG_TX;
                                if (ptr == PTR_W'(STAT_IDX)) stat_read <= 1'b1;
                            end else begin
                                state <= ENG_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tuner_reg_bank.sv
// Module: configuration registers with reset defaults, two read-only status
// bytes, power-on flag, read mux and the one-cycle trigger on a chosen register.
// Assumes write strobes last one cycle; writes outside the writable range are dropped.
module tuner_reg_bank
    import tuner_cfg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NUM_CFG   = 12,
    parameter int PTR_W     = 8,
    parameter int FLAG_W    = 3,
    parameter int TRIG_ADDR = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [DW-1:0]         rd_data,
    input  logic                  por_clr,
    input  logic [FLAG_W-1:0]     stat_flags,
    input  logic [DW-1:0]         stat_rb,
    output logic [NUM_CFG*DW-1:0] cfg_flat,
    output logic                  trig_pulse,
    output logic                  por_flag
);
    localparam int PAD_W = DW - 1 - FLAG_W;

    logic [DW-1:0] stat_hi;

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        logic [DW-1:0] q;
        // One configuration byte: default at reset, loaded on its own write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 q <= DW'(cfg_default(gi));
            else if (wr_en && wr_addr == PTR_W'(gi))    q <= wr_data;
        end
        assign cfg_flat[gi*DW +: DW] = q;
    end

    // Power-on flag: set by reset, cleared by the engine after a closed status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       por_flag <= 1'b1;
        else if (por_clr) por_flag <= 1'b0;
    end

    // Single-cycle start pulse after a write to the trigger register.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_pulse <= 1'b0;
        else        trig_pulse <= wr_en && (wr_addr == PTR_W'(TRIG_ADDR));
    end

    assign stat_hi = {por_flag, stat_flags, {PAD_W{1'b0}}};

    // Read mux over configuration bytes and both status bytes.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_addr == PTR_W'(i)) rd_data = cfg_flat[i*DW +: DW];
        end
        if (rd_addr == PTR_W'(NUM_CFG))     rd_data = stat_hi;
        if (rd_addr == PTR_W'(NUM_CFG + 1)) rd_data = stat_rb;
    end

endmodule

// File: rtl/tuner_cfg_slave.sv
// Module: top of the tuner configuration slave: line sampler, protocol engine
// and register bank. Assumes clk at least 10x the SCL rate; SDA is open-drain
// (sda_oe=1 pulls low). No clock stretching.
module tuner_cfg_slave #(
    parameter int         DW          = 8,
    parameter int         NUM_CFG     = 12,
    parameter int         TRIG_ADDR   = 5,
    parameter int         SYNC_STAGES = 2,
    parameter int         FLAG_W      = 3,
    parameter logic [5:0] ADDR_HI     = 6'b110000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic                  addr_strap,
    input  logic [FLAG_W-1:0]     stat_flags_in,
    input  logic [DW-1:0]         stat_rb_in,
    output logic [NUM_CFG*DW-1:0] cfg_flat,
    output logic                  vas_start
);
    localparam int NUM_STAT = 2;
    localparam int NUM_ADDR = NUM_CFG + NUM_STAT;
    localparam int PTR_W    = DW;

    logic             scl_rise;
    logic             scl_fall;
    logic             sda_lvl;
    logic             bus_start;
    logic             bus_stop;
    logic [DW-1:0]    rd_data;
    logic [PTR_W-1:0] rd_addr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [DW-1:0]    wr_data;
    logic             por_clr;
    logic             por_flag;

    i2c_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_slave_engine #(
        .DW      (DW),
        .PTR_W   (PTR_W),
        .NUM_ADDR(NUM_ADDR),
        .STAT_IDX(NUM_CFG),
        .ADDR_HI (ADDR_HI)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_strap(addr_strap),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .por_clr   (por_clr)
    );

    tuner_reg_bank #(
        .DW       (DW),
        .NUM_CFG  (NUM_CFG),
        .PTR_W    (PTR_W),
        .FLAG_W   (FLAG_W),
        .TRIG_ADDR(TRIG_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .por_clr   (por_clr),
        .stat_flags(stat_flags_in),
        .stat_rb   (stat_rb_in),
        .cfg_flat  (cfg_flat),
        .trig_pulse(vas_start),
        .por_flag  (por_flag)
    );

endmodule

// File: rtl/tuner_cfg_checker.sv
// Module: property checker for tuner_cfg_slave, attached by bind.
// Assumes the write strobe, power-on flag and STOP pulse of the top module.
module tuner_cfg_checker #(
    parameter int DW        = 8,
    parameter int NUM_CFG   = 12,
    parameter int PTR_W     = 8,
    parameter int TRIG_ADDR = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [PTR_W-1:0]      wr_addr,
    input logic [NUM_CFG*DW-1:0] cfg_flat,
    input logic                  vas_start,
    input logic                  por_flag,
    input logic                  bus_stop,
    input logic                  sda_oe
);
    // R9: trigger lasts exactly one cycle
    p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vas_start |=> !vas_start);

    // R9: trigger only follows a write to the trigger register
    p_trig_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vas_start |-> $past(wr_en && wr_addr == PTR_W'(TRIG_ADDR)));

    // R6: writes to status addresses leave configuration outputs untouched
    p_ro_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= PTR_W'(NUM_CFG)) |=> $stable(cfg_flat));

    // R8: power-on flag never returns without reset
    p_por_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !por_flag |=> !por_flag);

    // R8: power-on flag falls only two cycles after a STOP
    p_por_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(bus_stop, 2));

    // R11: SDA released after every STOP
    p_release_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

endmodule

bind tuner_cfg_slave tuner_cfg_checker #(
    .DW       (DW),
    .NUM_CFG  (NUM_CFG),
    .PTR_W    (PTR_W),
    .TRIG_ADDR(TRIG_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cfg_flat (cfg_flat),
    .vas_start(vas_start),
    .por_flag (por_flag),
    .bus_stop (bus_stop),
    .sda_oe   (sda_oe)
);

// File: tb/sim_tuner_cfg_slave.sv
`timescale 1ns/1ps
// Bench: bit-banged bus master with a scoreboard of expected bus bytes and ACKs.
module sim_tuner_cfg_slave;
    localparam int Q = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        strap = 1'b0;
    logic [2:0]  flags = 3'b101;
    logic [7:0]  rb = 8'h5A;
    logic        sda_oe;
    logic [95:0] cfg_flat;
    logic        vas_start;
    logic        sda_line;

    int          n_checks = 0;
    int          n_errors = 0;
    int          trig_cnt = 0;
    bit          done = 1'b0;

    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  obs_q[$];

    assign sda_line = sda_oe ? 1'b0 : m_sda;

    always #2.5 clk = ~clk;

    tuner_cfg_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .addr_strap   (strap),
        .stat_flags_in(flags),
        .stat_rb_in   (rb),
        .cfg_flat     (cfg_flat),
        .vas_start    (vas_start)
    );

    // Trigger pulse counter.
    always @(posedge clk) if (rst_n && vas_start) trig_cnt <= trig_cnt + 1;

    // Monitor: pops expected items and compares with observed bus results.
    always @(negedge clk) begin
        if (obs_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] o, e;
            string t;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (o !== e) begin
                n_errors++;
                $display("FAIL %s got %02h exp %02h", t, o, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got %0h exp %0h", t, got, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b0; #Q;
        m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b1; #Q;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string t);
        logic a;
        exp_q.push_back({7'd0, exp_ack});
        tag_q.push_back(t);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q;
            m_scl = 1'b1; #(2*Q);
            m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        a = ~sda_line; #Q;
        m_scl = 1'b0; #Q;
        obs_q.push_back({7'd0, a});
    endtask

    task automatic rd_byte(input logic nack, input logic [7:0] exp, input string t);
        logic [7:0] b;
        exp_q.push_back(exp);
        tag_q.push_back(t);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q;
            m_scl = 1'b1; #Q;
            b[i] = sda_line; #Q;
            m_scl = 1'b0;
        end
        #Q;
        m_sda = nack; #Q;
        m_scl = 1'b1; #(2*Q);
        m_scl = 1'b0; #Q;
        m_sda = 1'b1;
        obs_q.push_back(b);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [7:0] cfg_byte(input int k);
        return cfg_flat[8*k +: 8];
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [7:0] dflt[12];
        int t0;
        dflt = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01,
                 8'hC0, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h00};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        for (int k = 0; k < 12; k++) chk($sformatf("R5 default byte %0d", k), cfg_byte(k), dflt[k]);
        chk("R5 sda_oe at reset", sda_oe, 0);
        chk("R5 vas_start at reset", vas_start, 0);

        // R1 R3 write with auto-increment
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack on 0xC0");
        wr_byte(8'h08, 1'b1, "R3 ptr ack");
        wr_byte(8'h11, 1'b1, "R3 data ack");
        wr_byte(8'h22, 1'b1, "R3 data ack 2");
        bus_stop();
        settle();
        chk("R10 byte 8", cfg_byte(8), 8'h11);
        chk("R3 incremented byte 9", cfg_byte(9), 8'h22);
        chk("R9 no trigger on reg 8/9", trig_cnt, 0);
        chk("R11 released after stop", sda_oe, 0);

        // R4 read through repeated start
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h07, 1'b1, "R3 ptr ack");
        bus_start();
        wr_byte(8'hC1, 1'b1, "R4 read addr ack");
        rd_byte(1'b0, 8'hCC, "R4 read byte 7");
        rd_byte(1'b0, 8'h11, "R4 read byte 8");
        rd_byte(1'b1, 8'h22, "R4 read byte 9 nack");
        settle();
        chk("R4 released after nack", sda_oe, 0);
        bus_stop();
        settle();

        // R9 trigger on register 5 only
        t0 = trig_cnt;
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h04, 1'b1, "R3 ptr ack");
        wr_byte(8'h9A, 1'b1, "R3 data ack");
        wr_byte(8'h33, 1'b1, "R3 data ack");
        bus_stop();
        settle();
        chk("R9 one pulse for reg 5", trig_cnt - t0, 1);
        chk("R10 byte 4", cfg_byte(4), 8'h9A);
        chk("R10 byte 5", cfg_byte(5), 8'h33);
        t0 = trig_cnt;
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h04, 1'b1, "R3 ptr ack");
        wr_byte(8'h9B, 1'b1, "R3 data ack");
        bus_stop();
        settle();
        chk("R9 no pulse for reg 4", trig_cnt - t0, 0);

        // R6 status writes discarded, pointer wraps
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h0B, 1'b1, "R3 ptr ack");
        wr_byte(8'hA5, 1'b1, "R3 data ack");
        wr_byte(8'hEE, 1'b1, "R6 ack on 0x0C write");
        wr_byte(8'hEF, 1'b1, "R6 ack on 0x0D write");
        wr_byte(8'h7C, 1'b1, "R6 ack after wrap");
        bus_stop();
        settle();
        chk("R10 byte 11", cfg_byte(11), 8'hA5);
        chk("R6 wrap wrote byte 0", cfg_byte(0), 8'h7C);
        chk("R6 byte 1 untouched", cfg_byte(1), 8'h23);

        // R7 R8 status read; repeated start keeps the power-on flag
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h0B, 1'b1, "R3 ptr ack");
        bus_start();
        wr_byte(8'hC1, 1'b1, "R4 read addr ack");
        rd_byte(1'b0, 8'hA5, "R4 read byte 11");
        rd_byte(1'b0, 8'hD0, "R7 status hi with flag");
        rd_byte(1'b0, 8'h5A, "R7 status lo");
        rd_byte(1'b1, 8'h7C, "R6 read wraps to byte 0");
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h0C, 1'b1, "R3 ptr ack");
        bus_start();
        wr_byte(8'hC1, 1'b1, "R4 read addr ack");
        rd_byte(1'b1, 8'hD0, "R8 flag kept over repeated start");
        bus_stop();
        settle();
        flags = 3'b010;
        rb    = 8'h3C;
        bus_start();
        wr_byte(8'hC0, 1'b1, "R1 ack");
        wr_byte(8'h0C, 1'b1, "R3 ptr ack");
        bus_start();
        wr_byte(8'hC1, 1'b1, "R4 read addr ack");
        rd_byte(1'b0, 8'h20, "R8 flag cleared after stop");
        rd_byte(1'b1, 8'h3C, "R7 status lo updated");
        bus_stop();
        settle();

        // R2 foreign address ignored
        bus_start();
        wr_byte(8'hC2, 1'b0, "R2 no ack on 0xC2 with strap 0");
        wr_byte(8'h01, 1'b0, "R2 no ack on later byte");
        wr_byte(8'h55, 1'b0, "R2 no ack on later byte");
        bus_stop();
        settle();
        chk("R2 byte 1 unchanged", cfg_byte(1), 8'h23);

        // R1 strap high moves the address
        strap = 1'b1;
        settle();
        bus_start();
        wr_byte(8'hC0, 1'b0, "R1 no ack on 0xC0 with strap 1");
        bus_stop();
        bus_start();
        wr_byte(8'hC2, 1'b1, "R1 ack on 0xC2 with strap 1");
        wr_byte(8'h01, 1'b1, "R3 ptr ack");
        wr_byte(8'h66, 1'b1, "R3 data ack");
        bus_stop();
        settle();
        chk("R1 write through 0xC2", cfg_byte(1), 8'h66);
        bus_start();
        wr_byte(8'hC2, 1'b1, "R1 ack");
        wr_byte(8'h01, 1'b1, "R3 ptr ack");
        bus_start();
        wr_byte(8'hC3, 1'b1, "R1 ack on 0xC3");
        rd_byte(1'b1, 8'h66, "R4 read via 0xC3");
        bus_stop();
        settle();
        chk("R11 idle release", sda_oe, 0);

        repeat (20) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule